// File: doc/BRIEF.md
# UART Receive FIFO with Status Registers

This block is the receive half of a serial port's register file. A framing stage hands over each received character through a single-cycle push strobe. The strobe carries the data byte together with four error bits. The block queues these characters in a small circular buffer. Software drains the buffer through a word-addressed register bus.

Each data read removes the oldest character. The read returns the error bits above the byte and also copies them into a sticky status register. Software can inspect that register later and wipe it with any write. A flags register and three output pins report whether the buffer is empty or full, and whether the receive-level interrupt is active. The interrupt rises when the number of held characters reaches a trigger level and falls again when reads bring the count back below it.

A line control register holds a buffering enable bit. With the bit clear, the block behaves as a one-character holding register. With it set, the full depth is used. Toggling the bit discards everything held.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset rx_empty is 1, rx_full and rx_irq are 0. The status register (offset 1) and line control register (offset 11) read 0, and the trigger level is 1.
- R2: A read at word offset 0 returns the oldest held character as {error[3:0], data[7:0]} in bus_rdata[11:0] and removes it. Characters leave in arrival order.
- R3: Every read at offset 0 copies bits 11:8 of the returned entry into the status register, which reads back at offset 1 in bits 3:0.
- R4: Any write to offset 1 clears the status register to zero, whatever the write data.
- R5: Offset 6 reads the flags: bit 0 empty, bit 1 full, bit 2 interrupt level. Writes to offset 6 change nothing.
- R6: Offset 11 is an 8-bit read/write line control register with the buffer enable in bit 4. A write that changes bit 4 discards all held characters and resets the read position: empty becomes 1, full and the interrupt become 0. A write that keeps bit 4 leaves the contents alone.
- R7: With bit 4 clear, rx_full is 1 whenever one character is held. With bit 4 set, rx_full is 1 only when DEPTH (16) characters are held.
- R8: A push while rx_full is 1 is dropped and the count stays the same. An accepted push clears rx_empty. A pop clears rx_full and sets rx_empty when the count reaches zero.
- R9: rx_irq is set by a push that brings the count equal to the trigger level. It is cleared by a pop that leaves the count one below the trigger level. Otherwise it holds.
- R10: The trigger level is registered from input rx_trig every cycle and resets to 1.
- R11: A read at offset 0 while empty leaves the block empty, with the flags unchanged.
- R12: Read and write positions wrap modulo DEPTH, so order is kept across more than DEPTH characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Character strobe from the framing stage |
| push_data | input | 8 | Received byte |
| push_err | input | 4 | Error bits of the received byte |
| rx_trig | input | 5 | Interrupt trigger level (count) |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 12 | Read data, valid in the access cycle |
| rx_full | output | 1 | Receive buffer full |
| rx_empty | output | 1 | Receive buffer empty |
| rx_irq | output | 1 | Receive-level interrupt |

## Verification
The bench probes the full threshold in both enable states. In the disabled state a second character must be refused: a design that used the deep threshold there would accept it and return it later. The bench also fills to exactly 16, pushes one more, then drains; a design that overwrote the oldest slot would return the wrong order or the wrong count. It toggles the enable bit with characters held and also rewrites it with the same bit, so a flush that is missing, or one that fires on any write, shows up as stale or lost data. The interrupt is followed across a trigger level of 4, covering both the rise on the fourth push and the fall only at three remaining. Traffic wraps the circular buffer, so pointer wrap errors reorder data.

// File: rtl/urx_pkg.sv
package urx_pkg;
    // register word offsets (software map)
    localparam int unsigned OFS_DATA = 0;
    localparam int unsigned OFS_STAT = 1;
    localparam int unsigned OFS_FLAG = 6;
    localparam int unsigned OFS_LINE = 11;

    // flag register bit positions
    localparam int unsigned FLG_EMPTY = 0;
    localparam int unsigned FLG_FULL  = 1;
    localparam int unsigned FLG_IRQ   = 2;
    localparam int unsigned FLG_W     = 3;

    // buffer enable bit inside the line control register
    localparam int unsigned FEN_BIT = 4;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_POP,
        ACT_SCLR,
        ACT_LINE
    } bus_act_e;
endpackage

// File: rtl/urx_store.sv
module urx_store #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned ENTRY_W = 12,
    localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_entry
);
    logic [ENTRY_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [ENTRY_W-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_idx == PTR_W'(g))) begin
                slot_d = wr_entry;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d;
            end
        end
    end

    assign rd_entry = slot_q[rd_idx];
endmodule

// File: rtl/urx_regs.sv
module urx_regs
    import urx_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned RD_W   = 12,
    parameter int unsigned ERR_W  = 4,
    parameter int unsigned LCR_W  = 8
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LCR_W-1:0]  bus_wdata,
    input  logic [RD_W-1:0]   head_entry,
    input  logic [ERR_W-1:0]  status,
    input  logic [LCR_W-1:0]  line,
    input  logic [FLG_W-1:0]  flags,
    output logic              pop_req,
    output logic              stat_clr,
    output logic              line_wr,
    output logic [LCR_W-1:0]  line_wdata,
    output logic [RD_W-1:0]   bus_rdata
);
    bus_act_e act;

    always_comb begin
        act = ACT_NONE;
        if (bus_en) begin
            if (bus_we) begin
                if (bus_addr == ADDR_W'(OFS_STAT)) act = ACT_SCLR;
                if (bus_addr == ADDR_W'(OFS_LINE)) act = ACT_LINE;
            end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
                act = ACT_POP;
            end
        end
    end

    assign pop_req    = (act == ACT_POP);
    assign stat_clr   = (act == ACT_SCLR);
    assign line_wr    = (act == ACT_LINE);
    assign line_wdata = bus_wdata;

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (bus_addr)
                ADDR_W'(OFS_DATA): bus_rdata = head_entry;
                ADDR_W'(OFS_STAT): bus_rdata = RD_W'(status);
                ADDR_W'(OFS_FLAG): bus_rdata = RD_W'(flags);
                ADDR_W'(OFS_LINE): bus_rdata = RD_W'(line);
                default:           bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/urx_ctrl.sv
module urx_ctrl
    import urx_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ERR_W  = 4,
    parameter int unsigned LCR_W  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned SUM_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             pop_req,
    input  logic             stat_clr,
    input  logic             line_wr,
    input  logic [LCR_W-1:0] line_wdata,
    input  logic [ERR_W-1:0] head_err,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic             full_o,
    output logic             empty_o,
    output logic             irq_o,
    output logic [ERR_W-1:0] status_o,
    output logic [LCR_W-1:0] line_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PTR_W-1:0] rd_ptr;
        logic             empty;
        logic             full;
        logic             irq;
        logic [ERR_W-1:0] status;
        logic [LCR_W-1:0] line;
        logic [CNT_W-1:0] trig;
    } state_t;

    state_t st_d, st_q;

    logic             flip;
    logic             push_ok;
    logic             pop_ok;
    logic [CNT_W-1:0] cnt_n;
    logic [SUM_W-1:0] wr_sum;

    always_comb begin
        flip    = line_wr && (line_wdata[FEN_BIT] != st_q.line[FEN_BIT]);
        push_ok = push_valid && !st_q.full && !flip;
        pop_ok  = pop_req && (st_q.cnt != '0) && !flip;
        cnt_n   = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        wr_sum  = SUM_W'(st_q.rd_ptr) + SUM_W'(st_q.cnt);
        if (wr_sum >= SUM_W'(DEPTH)) begin
            wr_sum = wr_sum - SUM_W'(DEPTH);
        end

        st_d      = st_q;
        st_d.trig = rx_trig;

        if (pop_req)  st_d.status = head_err;
        if (stat_clr) st_d.status = '0;
        if (line_wr)  st_d.line   = line_wdata;

        if (flip) begin
            st_d.cnt    = '0;
            st_d.rd_ptr = '0;
            st_d.empty  = 1'b1;
            st_d.full   = 1'b0;
            st_d.irq    = 1'b0;
        end else begin
            st_d.cnt   = cnt_n;
            st_d.empty = (cnt_n == '0);
            st_d.full  = st_q.line[FEN_BIT] ? (cnt_n == CNT_W'(DEPTH))
                                            : (cnt_n != '0);
            if (pop_ok) begin
                st_d.rd_ptr = (st_q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0
                                                                 : st_q.rd_ptr + PTR_W'(1);
            end
            if (push_ok && (cnt_n == st_q.trig)) begin
                st_d.irq = 1'b1;
            end else if (pop_ok && (cnt_n == st_q.trig - CNT_W'(1))) begin
                st_d.irq = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.empty  <= 1'b1;
            st_q.trig   <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en    = push_ok;
    assign wr_idx   = PTR_W'(wr_sum);
    assign rd_idx   = st_q.rd_ptr;
    assign full_o   = st_q.full;
    assign empty_o  = st_q.empty;
    assign irq_o    = st_q.irq;
    assign status_o = st_q.status;
    assign line_o   = st_q.line;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R8

    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full_o && !pop_req && !line_wr) |=> $stable(st_q.cnt)); // R8

    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !full_o && !line_wr) |=> !empty_o); // R8

    AST_POP_UNFULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !empty_o && !line_wr) |=> !full_o); // R8

    AST_STAT_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (status_o == '0)); // R4

    AST_FLUSH_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> (empty_o && !full_o && !irq_o)); // R6

    AST_IRQ_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(push_valid)); // R9
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import urx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ERR_W  = 4,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned LCR_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_valid,
    input  logic [DATA_W-1:0]            push_data,
    input  logic [ERR_W-1:0]             push_err,
    input  logic [$clog2(DEPTH+1)-1:0]   rx_trig,
    input  logic                         bus_en,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [LCR_W-1:0]             bus_wdata,
    output logic [DATA_W+ERR_W-1:0]      bus_rdata,
    output logic                         rx_full,
    output logic                         rx_empty,
    output logic                         rx_irq
);
    localparam int unsigned ENTRY_W = DATA_W + ERR_W;
    localparam int unsigned PTR_W   = $clog2(DEPTH);

    logic               wr_en;
    logic [PTR_W-1:0]   wr_idx;
    logic [PTR_W-1:0]   rd_idx;
    logic [ENTRY_W-1:0] head_entry;
    logic               pop_req;
    logic               stat_clr;
    logic               line_wr;
    logic [LCR_W-1:0]   line_wdata;
    logic [ERR_W-1:0]   status;
    logic [LCR_W-1:0]   line;
    logic [FLG_W-1:0]   flags;

    urx_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry ({push_err, push_data}),
        .rd_idx   (rd_idx),
        .rd_entry (head_entry)
    );

    urx_ctrl #(.DEPTH(DEPTH), .ERR_W(ERR_W), .LCR_W(LCR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .rx_trig    (rx_trig),
        .pop_req    (pop_req),
        .stat_clr   (stat_clr),
        .line_wr    (line_wr),
        .line_wdata (line_wdata),
        .head_err   (head_entry[ENTRY_W-1:DATA_W]),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .full_o     (rx_full),
        .empty_o    (rx_empty),
        .irq_o      (rx_irq),
        .status_o   (status),
        .line_o     (line)
    );

    always_comb begin
        flags            = '0;
        flags[FLG_EMPTY] = rx_empty;
        flags[FLG_FULL]  = rx_full;
        flags[FLG_IRQ]   = rx_irq;
    end

    urx_regs #(.ADDR_W(ADDR_W), .RD_W(ENTRY_W), .ERR_W(ERR_W), .LCR_W(LCR_W)) u_regs (
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .head_entry (head_entry),
        .status     (status),
        .line       (line),
        .flags      (flags),
        .pop_req    (pop_req),
        .stat_clr   (stat_clr),
        .line_wr    (line_wr),
        .line_wdata (line_wdata),
        .bus_rdata  (bus_rdata)
    );
endmodule

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_data = '0;
    logic [3:0]  push_err = '0;
    logic [4:0]  rx_trig = 5'd1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [11:0] bus_rdata;
    logic        rx_full, rx_empty, rx_irq;

    uart_rx_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_err(push_err), .rx_trig(rx_trig), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_irq(rx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [11:0] exp_q[$];
    bit          m_fen = 0;
    bit          m_irq = 0;
    int          m_trig = 1;
    string       mon_req = "R2";
    event        mon_ev;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit m_full();
        return m_fen ? (exp_q.size() == DEPTH) : (exp_q.size() != 0);
    endfunction

    task automatic chk_flags(input string req);
        int act = {29'd0, rx_irq, rx_full, rx_empty};
        int exp = {29'd0, m_irq, m_full(), exp_q.size() == 0};
        chk(act == exp, req, act, exp);
    endtask

    // scoreboard monitor: compares each popped character with the queue head
    always @(mon_ev) begin
        logic [11:0] want;
        want = exp_q.pop_front();
        chk(bus_rdata == want, mon_req, bus_rdata, want);
    end

    task automatic push(input logic [7:0] d, input logic [3:0] e);
        bit acc = !m_full();
        @(negedge clk);
        push_valid = 1'b1; push_data = d; push_err = e;
        @(posedge clk); #1;
        push_valid = 1'b0;
        if (acc) begin
            exp_q.push_back({e, d});
            if (exp_q.size() == m_trig) m_irq = 1;
        end
    endtask

    task automatic pop(input string req);
        bit have = (exp_q.size() != 0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 4'd0;
        #1;
        if (have) begin
            mon_req = req;
            -> mon_ev;
        end
        @(posedge clk); #1;
        bus_en = 1'b0;
        if (have && exp_q.size() == m_trig - 1) m_irq = 0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [11:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [11:0] v;
        logic [11:0] last;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk({rx_irq, rx_full, rx_empty} == 3'b001, "R1 pins", {rx_irq, rx_full, rx_empty}, 1);
        rd_reg(4'd6, v);  chk(v == 12'h001, "R1 flags", v, 1);
        rd_reg(4'd1, v);  chk(v == 12'h000, "R1 status", v, 0);
        rd_reg(4'd11, v); chk(v == 12'h000, "R1 line", v, 0);

        // R10 trigger resets to 1: first push raises irq; R7 disabled -> full at one
        push(8'h41, 4'hA);
        chk_flags("R10/R7 single entry");
        push(8'h42, 4'h3);
        chk_flags("R8 drop while full");
        wr_reg(4'd6, 8'hFF);
        rd_reg(4'd6, v);  chk(v == 12'h006, "R5 flags write ignored", v, 6);
        pop("R2 oldest with errors");
        chk_flags("R9 irq lowered at trig-1");
        rd_reg(4'd1, v);  chk(v == 12'h00A, "R3 status copied", v, 'hA);
        wr_reg(4'd1, 8'h5A);
        rd_reg(4'd1, v);  chk(v == 12'h000, "R4 status cleared", v, 0);

        // R6 enable buffering
        wr_reg(4'd11, 8'h10); m_fen = 1;
        rd_reg(4'd11, v); chk(v == 12'h010, "R6 line readback", v, 'h10);
        m_irq = 0;
        for (int i = 0; i < 15; i++) push(8'(8'h10 + i), 4'(i));
        chk_flags("R7 fifteen not full");
        push(8'hF0, 4'h7);
        chk_flags("R7 full at depth");
        push(8'hEE, 4'h9);
        chk_flags("R8 push into full dropped");
        for (int i = 0; i < DEPTH; i++) begin
            last = exp_q[0];
            pop("R2 drain order");
        end
        chk_flags("R8 empty after drain");
        rd_reg(4'd1, v); chk(v == 12'(last[11:8]), "R3 status of last pop", v, last[11:8]);

        // R12 wrap
        for (int i = 0; i < 10; i++) push(8'(8'h60 + i), 4'(i + 1));
        for (int i = 0; i < 10; i++) pop("R12 wrap");
        for (int i = 0; i < 12; i++) push(8'(8'h80 + i), 4'(15 - i));
        for (int i = 0; i < 12; i++) pop("R12 wrap across end");
        chk_flags("R12 empty after wrap");

        // R9 trigger level 4
        @(negedge clk); rx_trig = 5'd4; m_trig = 4;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) push(8'(8'hA0 + i), 4'h1);
        chk_flags("R9 below trigger");
        push(8'hA3, 4'h2);
        chk_flags("R9 raised at trigger");
        push(8'hA4, 4'h2);
        pop("R9 pop");
        chk_flags("R9 held above trig-1");
        pop("R9 pop");
        chk_flags("R9 lowered at trig-1");

        // R6 same-bit write keeps contents, flip flushes
        wr_reg(4'd11, 8'h13);
        chk_flags("R6 same bit keeps");
        rd_reg(4'd11, v); chk(v == 12'h013, "R6 line readback", v, 'h13);
        wr_reg(4'd11, 8'h03);
        m_fen = 0; m_irq = 0; exp_q.delete();
        chk_flags("R6 flip flushes");
        push(8'h55, 4'h4);
        pop("R6 read position reset");

        // R11 read while empty
        pop("R11");
        chk_flags("R11 empty read no effect");
        push(8'h77, 4'h1);
        chk_flags("R11 push after empty read");
        pop("R11 data after empty read");
        chk_flags("R11 final");

        done = 1;
        finish_run();
    end
endmodule